// File: doc/BRIEF.md
# Strided Interleaved Bank Controller

This block runs one vector load or store stream at a time against a set of interleaved memory banks. A stream is launched with a base address, a stride and an element count. The stride is latched once at launch, so a single command covers the whole strided access. After launch the block steps through element addresses, at most one per cycle. Each address selects a bank through its low address bits. The remaining high bits index a word inside that bank.

Each bank is modelled as synchronous storage with a fixed recovery time. After an access, a bank refuses new accesses for a set number of cycles. When the next element targets a bank that is still recovering, the address stepper holds and the cycle is counted as a stall. The stream continues on the first cycle the bank becomes free. This makes conflicts caused by the stride visible in the schedule. Examples are a stride of zero, or a stride that shares too many factors with the bank count. Load data returns in element order. A completion pulse marks the end of each stream.

Top module: `strided_bank_ctrl`

## Requirements
- R1: After synchronous reset, issue_valid, ld_valid, done and stall are low and stall_count is zero.
- R2: Element i of a stream uses address (base + i*stride) mod 2^ADDR_W. Elements issue in order, at most one per cycle, and the first element may issue in the cycle after start is sampled.
- R3: The bank of an element is its address mod NUM_BANKS, which is the low log2(NUM_BANKS) address bits. issue_bank reports that bank, and the word inside the bank is the remaining high address bits.
- R4: After an access, a bank accepts no other access for BUSY_CYC cycles. An access in cycle t allows the next access to that bank no earlier than cycle t+BUSY_CYC. When the current element's bank is still recovering, stall is high, issue_valid is low and the address holds. The element issues in the first cycle its bank is free.
- R5: When the stride is odd, it is relatively prime to the bank count. In that case a stream started with all banks idle never stalls and issues one element every cycle.
- R6: A stride of zero is legal. Every element then hits the same bank, so consecutive elements issue exactly BUSY_CYC cycles apart.
- R7: A load element issued in cycle t raises ld_valid in cycle t+1, with ld_data equal to the word last stored at that address. Load data arrives in element order.
- R8: A store element writes st_data, as presented in its issue cycle, to its address.
- R9: done is a one-cycle pulse in the cycle after the last element issues. A start with elem_count zero issues nothing and pulses done in the cycle after start is sampled.
- R10: stall_count equals the number of stall cycles in the current stream. It is cleared when a stream is accepted and holds its value after the stream ends.
- R11: A start raised while a stream is running is ignored. The running stream's addresses, timing and data are unchanged.
- R12: The visited bank count is NUM_BANKS / gcd(stride, NUM_BANKS). When that count is below BUSY_CYC, the stream stalls; with the default 16 banks and busy time 4, a stride of 8 gives stall_count > 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a stream (sampled only while idle) |
| op_store | input | 1 | 1 = store stream, 0 = load stream |
| base_addr | input | ADDR_W | Address of element 0 |
| stride | input | ADDR_W | Address distance between consecutive elements |
| elem_count | input | ADDR_W+1 | Number of elements in the stream |
| st_data | input | DATA_W | Store data for the element issuing this cycle |
| issue_valid | output | 1 | An element accesses its bank this cycle |
| issue_addr | output | ADDR_W | Address of the current element |
| issue_bank | output | log2(NUM_BANKS) | Bank of the current element |
| stall | output | 1 | Current element waits on a recovering bank |
| ld_valid | output | 1 | ld_data holds a load element |
| ld_data | output | DATA_W | Returned load word |
| done | output | 1 | One-cycle completion pulse |
| stall_count | output | STALL_W | Stall cycles of the current or last stream |

## Verification
The embedded assertions check four rules on every cycle. No bank is accessed while it is recovering. Each issue advances the address by exactly the latched stride. Load data only appears after a load issue. Stall cycles always advance the stall counter.

Other properties need the bench's scenarios, because they depend on the arithmetic of whole streams. These are the exact issue schedule for each stride, the absence of stalls for odd strides, and serialization at stride zero. The bench also shows data round-trips through the banks, address wrap-around, the empty stream, and a start ignored mid-stream.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } op_e;

    typedef enum logic {
        GEN_IDLE = 1'b0,
        GEN_RUN  = 1'b1
    } gen_state_e;

    // Width of a per-bank recovery counter that must hold busy-1.
    function automatic int unsigned recov_cnt_w(input int unsigned busy);
        return (busy <= 2) ? 1 : $clog2(busy);
    endfunction

endpackage

// File: rtl/sbc_addr_gen.sv
module sbc_addr_gen
    import sbc_pkg::*;
#(
    parameter int unsigned AW  = 8,
    parameter int unsigned CW  = AW + 1,
    parameter int unsigned SCW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  op_e            op_i,
    input  logic [AW-1:0]  base_i,
    input  logic [AW-1:0]  stride_i,
    input  logic [CW-1:0]  count_i,
    input  logic           bank_free_i,
    output logic           issue_o,
    output logic           stall_o,
    output logic [AW-1:0]  addr_o,
    output op_e            op_o,
    output logic           done_o,
    output logic [SCW-1:0] stall_cnt_o
);

    gen_state_e     state_q;
    logic [AW-1:0]  addr_q;
    logic [AW-1:0]  stride_q;
    logic [CW-1:0]  left_q;
    op_e            op_q;
    logic           done_q;
    logic [SCW-1:0] stall_q;
    logic           running;

    assign running = (state_q == GEN_RUN);
    assign issue_o = running && bank_free_i;
    assign stall_o = running && !bank_free_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= GEN_IDLE;
            addr_q   <= '0;
            stride_q <= '0;
            left_q   <= '0;
            op_q     <= OP_LOAD;
            done_q   <= 1'b0;
            stall_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                GEN_IDLE: begin
                    if (start_i) begin
                        addr_q   <= base_i;
                        stride_q <= stride_i;
                        left_q   <= count_i;
                        op_q     <= op_i;
                        stall_q  <= '0;
                        if (count_i == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= GEN_RUN;
                        end
                    end
                end
                default: begin
                    if (bank_free_i) begin
                        addr_q <= addr_q + stride_q;
                        left_q <= left_q - 1'b1;
                        if (left_q == CW'(1)) begin
                            state_q <= GEN_IDLE;
                            done_q  <= 1'b1;
                        end
                    end else if (stall_q != '1) begin
                        stall_q <= stall_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign addr_o      = addr_q;
    assign op_o        = op_q;
    assign done_o      = done_q;
    assign stall_cnt_o = stall_q;

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_o && left_q != CW'(1)) |=> (addr_q == $past(addr_q) + $past(stride_q)));

    // R9
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_o && left_q == CW'(1)) |=> done_o);

    // R10
    stall_counted_chk: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> (stall_cnt_o != '0));

    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (running && start_i) |=> ($stable(stride_q) && $stable(op_q)));

endmodule

// File: rtl/sbc_bank_timer.sv
module sbc_bank_timer
    import sbc_pkg::*;
#(
    parameter int unsigned NB   = 16,
    parameter int unsigned BUSY = 4,
    parameter int unsigned NBL  = $clog2(NB)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           hit_i,
    input  logic [NBL-1:0] bank_i,
    output logic [NB-1:0]  busy_o
);

    localparam int unsigned RW = recov_cnt_w(BUSY);
    localparam logic [RW-1:0] RELOAD = RW'(BUSY - 1);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [RW-1:0] cnt_q;
        logic          sel;

        assign sel = hit_i && (bank_i == NBL'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (sel) begin
                cnt_q <= RELOAD;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        assign busy_o[b] = (cnt_q != '0);

        // R4
        bank_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            sel |-> (cnt_q == '0));
    end

endmodule

// File: rtl/sbc_bank_array.sv
module sbc_bank_array #(
    parameter int unsigned NB  = 16,
    parameter int unsigned NBL = $clog2(NB),
    parameter int unsigned IW  = 4,
    parameter int unsigned DW  = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we_i,
    input  logic           re_i,
    input  logic [NBL-1:0] bank_i,
    input  logic [IW-1:0]  idx_i,
    input  logic [DW-1:0]  wdata_i,
    output logic [DW-1:0]  rdata_o
);

    localparam int unsigned DEPTH = 1 << IW;

    logic [DW-1:0]  rd_bank [NB];
    logic [NBL-1:0] rbank_q;

    for (genvar b = 0; b < NB; b++) begin : g_store
        logic [DW-1:0] mem [DEPTH];
        logic [DW-1:0] rd_q;
        logic          sel;

        assign sel = (bank_i == NBL'(b));

        always_ff @(posedge clk) begin
            if (sel && we_i) begin
                mem[idx_i] <= wdata_i;
            end
            if (sel && re_i) begin
                rd_q <= mem[idx_i];
            end
        end

        assign rd_bank[b] = rd_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbank_q <= '0;
        end else if (re_i) begin
            rbank_q <= bank_i;
        end
    end

    assign rdata_o = rd_bank[rbank_q];

endmodule

// File: rtl/strided_bank_ctrl.sv
module strided_bank_ctrl
    import sbc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned NUM_BANKS = 16,
    parameter int unsigned BUSY_CYC  = 4,
    parameter int unsigned DATA_W    = 64,
    parameter int unsigned STALL_W   = 16,
    localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
    localparam int unsigned IDX_W    = ADDR_W - BANK_W,
    localparam int unsigned CNT_W    = ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               op_store,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [ADDR_W-1:0]  stride,
    input  logic [CNT_W-1:0]   elem_count,
    input  logic [DATA_W-1:0]  st_data,
    output logic               issue_valid,
    output logic [ADDR_W-1:0]  issue_addr,
    output logic [BANK_W-1:0]  issue_bank,
    output logic               stall,
    output logic               ld_valid,
    output logic [DATA_W-1:0]  ld_data,
    output logic               done,
    output logic [STALL_W-1:0] stall_count
);

    logic [ADDR_W-1:0]    cur_addr;
    logic [BANK_W-1:0]    cur_bank;
    logic [IDX_W-1:0]     cur_idx;
    logic [NUM_BANKS-1:0] bank_busy;
    logic                 bank_free;
    logic                 issue;
    op_e                  cur_op;
    logic                 ld_valid_q;

    assign cur_bank  = cur_addr[BANK_W-1:0];
    assign cur_idx   = cur_addr[ADDR_W-1:BANK_W];
    assign bank_free = !bank_busy[cur_bank];

    sbc_addr_gen #(
        .AW  (ADDR_W),
        .CW  (CNT_W),
        .SCW (STALL_W)
    ) gen_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .op_i        (op_e'(op_store)),
        .base_i      (base_addr),
        .stride_i    (stride),
        .count_i     (elem_count),
        .bank_free_i (bank_free),
        .issue_o     (issue),
        .stall_o     (stall),
        .addr_o      (cur_addr),
        .op_o        (cur_op),
        .done_o      (done),
        .stall_cnt_o (stall_count)
    );

    sbc_bank_timer #(
        .NB   (NUM_BANKS),
        .BUSY (BUSY_CYC),
        .NBL  (BANK_W)
    ) timer_i (
        .clk    (clk),
        .rst    (rst),
        .hit_i  (issue),
        .bank_i (cur_bank),
        .busy_o (bank_busy)
    );

    sbc_bank_array #(
        .NB  (NUM_BANKS),
        .NBL (BANK_W),
        .IW  (IDX_W),
        .DW  (DATA_W)
    ) banks_i (
        .clk     (clk),
        .rst     (rst),
        .we_i    (issue && cur_op == OP_STORE),
        .re_i    (issue && cur_op == OP_LOAD),
        .bank_i  (cur_bank),
        .idx_i   (cur_idx),
        .wdata_i (st_data),
        .rdata_o (ld_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_valid_q <= 1'b0;
        end else begin
            ld_valid_q <= issue && (cur_op == OP_LOAD);
        end
    end

    assign issue_valid = issue;
    assign issue_addr  = cur_addr;
    assign issue_bank  = cur_bank;
    assign ld_valid    = ld_valid_q;

    // R7
    ld_follows_issue_chk: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> ($past(issue_valid) && $past(cur_op) == OP_LOAD));

endmodule

// File: tb/strided_bank_ctrl_tb_top.sv
module strided_bank_ctrl_tb_top;

    localparam int AW   = 8;
    localparam int NB   = 16;
    localparam int BUSY = 4;
    localparam int DW   = 64;
    localparam int WORDS = 1 << AW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst, start, op_store;
    logic [AW-1:0] base_addr, stride;
    logic [AW:0]   elem_count;
    logic [DW-1:0] st_data;
    logic          issue_valid, stall, ld_valid, done;
    logic [AW-1:0] issue_addr;
    logic [3:0]    issue_bank;
    logic [DW-1:0] ld_data;
    logic [15:0]   stall_count;
    logic [31:0]   salt;

    assign st_data = {salt, 24'h0, issue_addr};

    strided_bank_ctrl dut_i (
        .clk(clk), .rst(rst), .start(start), .op_store(op_store),
        .base_addr(base_addr), .stride(stride), .elem_count(elem_count),
        .st_data(st_data), .issue_valid(issue_valid), .issue_addr(issue_addr),
        .issue_bank(issue_bank), .stall(stall), .ld_valid(ld_valid),
        .ld_data(ld_data), .done(done), .stall_count(stall_count)
    );

    int total = 0;
    int bad   = 0;
    logic [DW-1:0] ref_mem [WORDS];
    int exp_t [WORDS];
    int exp_a [WORDS];
    int last_exp_stalls;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic int gcd(input int a, input int b);
        int x = a, y = b;
        while (y != 0) begin
            int r = x % y;
            x = y;
            y = r;
        end
        return x;
    endfunction

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic run_stream(input int base, input int strd, input int cnt,
                              input bit st, input int salt_v, input bit poke);
        int free_at [NB];
        int tp, dt, k, j;
        bit exp_iss, exp_ld, exp_stall;
        for (int b = 0; b < NB; b++) free_at[b] = 0;
        tp = -1;
        for (int i = 0; i < cnt; i++) begin
            int a, b, t;
            a = (base + i * strd) % WORDS;
            b = a % NB;
            t = (tp + 1 > free_at[b]) ? tp + 1 : free_at[b];
            free_at[b] = t + BUSY;
            exp_t[i] = t;
            exp_a[i] = a;
            tp = t;
        end
        dt = (cnt == 0) ? 0 : tp + 1;
        last_exp_stalls = (cnt == 0) ? 0 : tp + 1 - cnt;

        @(negedge clk);
        salt       = 32'(salt_v);
        start      = 1'b1;
        op_store   = st;
        base_addr  = AW'(base);
        stride     = AW'(strd);
        elem_count = (AW+1)'(cnt);
        @(negedge clk);
        start = 1'b0;
        k = 0;
        j = 0;
        for (int t = 0; t <= dt + 1; t++) begin
            if (poke && t == 1) begin
                // R11: competing start while the stream runs
                start      = 1'b1;
                op_store   = 1'b1;
                base_addr  = 8'h33;
                stride     = 8'h01;
                elem_count = 9'd5;
            end else begin
                start = 1'b0;
            end
            exp_iss   = (k < cnt) && (exp_t[k] == t);
            exp_stall = (cnt > 0) && (t <= tp) && !exp_iss;
            chk(issue_valid == exp_iss, "R4", "issue_valid timing", 64'(issue_valid), 64'(exp_iss));
            chk(stall == exp_stall, "R4", "stall flag", 64'(stall), 64'(exp_stall));
            if (issue_valid && exp_iss) begin
                chk(issue_addr == AW'(exp_a[k]), "R2", "element address", 64'(issue_addr), 64'(exp_a[k]));
                chk(issue_bank == 4'(exp_a[k] % NB), "R3", "bank select", 64'(issue_bank), 64'(exp_a[k] % NB));
                if (st) ref_mem[exp_a[k]] = {32'(salt_v), 24'h0, 8'(exp_a[k])};
                k++;
            end
            exp_ld = !st && (j < cnt) && (exp_t[j] == t - 1);
            chk(ld_valid == exp_ld, "R7", "ld_valid timing", 64'(ld_valid), 64'(exp_ld));
            if (ld_valid && exp_ld) begin
                chk(ld_data == ref_mem[exp_a[j]], "R7", "load data", ld_data, ref_mem[exp_a[j]]);
                j++;
            end
            chk(done == (t == dt), "R9", "done pulse", 64'(done), 64'(t == dt));
            @(negedge clk);
        end
        start = 1'b0;
        chk(stall_count == 16'(last_exp_stalls), "R10", "stall count", 64'(stall_count), 64'(last_exp_stalls));
        repeat (BUSY + 2) @(negedge clk);
    endtask

    initial begin
        #(10ns * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; start = 1'b0; op_store = 1'b0;
        base_addr = '0; stride = '0; elem_count = '0; salt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(issue_valid == 1'b0, "R1", "issue_valid after reset", 64'(issue_valid), 0);
        chk(ld_valid == 1'b0, "R1", "ld_valid after reset", 64'(ld_valid), 0);
        chk(done == 1'b0, "R1", "done after reset", 64'(done), 0);
        chk(stall == 1'b0, "R1", "stall after reset", 64'(stall), 0);
        chk(stall_count == 0, "R1", "stall_count after reset", 64'(stall_count), 0);

        // R8 / R5: fill every word with a unit-stride store
        run_stream(0, 1, WORDS, 1'b1, 32'h1111, 1'b0);
        chk(last_exp_stalls == 0 && stall_count == 0, "R5", "unit stride fill stalls", 64'(stall_count), 0);

        // Stride sweep of loads
        for (int s = 0; s < 18; s++) begin
            run_stream((s * 7) % WORDS, s, 24, 1'b0, 0, 1'b0);
            if (gcd(s, NB) == 1)
                chk(stall_count == 0, "R5", "odd stride stalls", 64'(stall_count), 0);
            if (s % NB == 0)
                // R6: same bank each time, BUSY apart
                chk(stall_count == 16'(23 * (BUSY - 1)), "R6", "stride zero serialization",
                    64'(stall_count), 64'(23 * (BUSY - 1)));
            if (s == 8)
                chk(stall_count != 0, "R12", "stride 8 must stall", 64'(stall_count), 64'(last_exp_stalls));
        end

        // R8: strided store then full readback
        run_stream(5, 3, 40, 1'b1, 32'h2222, 1'b0);
        run_stream(250, 6, 30, 1'b1, 32'h3333, 1'b0);
        run_stream(0, 1, WORDS, 1'b0, 0, 1'b0);
        // R2 wrap-around load
        run_stream(240, 13, 50, 1'b0, 0, 1'b0);

        // R9 empty stream
        run_stream(17, 4, 0, 1'b0, 0, 1'b0);
        chk(issue_valid == 1'b0, "R9", "no issue after empty stream", 64'(issue_valid), 0);

        // R11 start ignored mid-stream (trace checks inside)
        run_stream(2, 2, 16, 1'b0, 0, 1'b1);
        chk(issue_valid == 1'b0, "R11", "ignored start launched nothing", 64'(issue_valid), 0);
        run_stream(0, 1, WORDS, 1'b0, 0, 1'b0);

        finish_run();
    end

endmodule